// File: doc/BRIEF.md
# UART Receive Break and Framing-Error Tracker

This block sits between an asynchronous serial receiver core and the receive FIFO that software drains. Every character the receiver delivers is stored together with a one-bit framing-error tag. The FIFO head drives a framing-error status that always describes the character the next pop will return, not the character most recently received.

The block also watches the synchronized receive line for a break condition. A break is a character with a framing error followed by more receive data while the line never returns to mark. When a break is recognised, a sticky break flag is raised and the null characters the receiver produces during the break are kept out of the FIFO. Storage of nulls resumes once the line returns to mark. Software clears the break flag with a read-then-write-zero sequence.

Top module: `uart_rx_brk_tracker`

## Requirements
- R1: Each accepted character is stored as an 8-bit data value plus a framing-error tag and is returned in arrival order. `head_data` and `head_ferr` show the oldest stored entry, and `head_ferr` reads 0 whenever the FIFO is empty.
- R2: The FIFO holds `DEPTH` (default 16) entries and asserts `fifo_full` at that count. A character offered while the FIFO is full is dropped and the stored contents stay as they were.
- R3: A pop strobe while the FIFO is empty has no effect. The next character stored after it becomes the head.
- R4: The receive line `rxd` passes through a two-flop synchronizer before break or mark detection uses it. Both synchronizer flops reset to mark (1).
- R5: A character with a framing error arms the detector. If another character then arrives while the synchronized line has stayed at space (0) since the arming, `brk_flag` reads 1 after that clock edge.
- R6: From the character that sets the break onward, and while the line stays at space, characters with value 0x00 are not stored. Non-zero characters are still stored.
- R7: When the synchronized line returns to mark, the break ends. A 0x00 character offered from the third clock edge after `rxd` rises onward is stored again.
- R8: If the line returns to mark between the framing-error character and the next character, the detector disarms. The next character is stored and `brk_flag` stays 0.
- R9: `brk_flag` clears only on a write with `stat_wdata` = 0 that follows a `stat_rd` strobe during which the flag read 1, with no write in between. A write of 0 without that read, or a write of 1, leaves the flag set. Any write consumes a pending read.
- R10: If a break set event and a valid clearing write fall on the same clock edge, `brk_flag` stays 1.
- R11: After reset, `brk_flag` and `head_ferr` are 0 and `fifo_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_vld | input | 1 | Character-valid strobe from the receiver core |
| ch_data | input | 8 | Received character |
| ch_ferr | input | 1 | Framing error seen on this character |
| rxd | input | 1 | Raw receive line level, asynchronous |
| pop | input | 1 | Removes the head entry of the FIFO |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 1 | Value written to the break flag |
| head_data | output | 8 | Data of the FIFO head entry |
| head_ferr | output | 1 | Framing-error tag of the head entry, 0 when empty |
| fifo_empty | output | 1 | FIFO holds no entries |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| brk_flag | output | 1 | Sticky break-detected flag |

## Verification
A stored character appears at the FIFO head one clock edge after its strobe, and `brk_flag` changes on the same edge as the strobe or write that sets or clears it. A change on `rxd` takes two edges to reach the detector and a third edge to end the break. The bench drives every input on the falling edge. It compares head data and tags against a scoreboard queue only at the falling edge after the edge that updates them. After each line change it waits three full cycles before sending the next character, so every comparison falls in a cycle where the result has already settled.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef struct packed {
    logic              ferr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  output logic line_sync
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d[0] = line_async;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  // flops come out of reset at mark so an idle line causes no event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '1;
    else        stage_q <= stage_d;
  end

  assign line_sync = stage_q[STAGES-1];
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import uart_brk_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  rx_entry_t        push_entry,
  input  logic             pop,
  output rx_entry_t        head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  rx_entry_t        store_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage array has no reset; entries are only read once counted
  always_ff @(posedge clk) begin
    if (do_push) store_q[wr_ptr_q] <= push_entry;
  end

  assign head  = store_q[rd_ptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ch_vld,
  input  logic ch_ferr,
  input  logic line_s,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic stat_wdata,
  output logic in_brk,
  output logic brk_flag
);
  logic armed_q,   armed_d;
  logic active_q,  active_d;
  logic rd_seen_q, rd_seen_d;
  logic flag_q,    flag_d;
  logic set_evt, clr_evt;

  // a framing error arms; any mark on the line disarms and ends a break
  assign set_evt = ch_vld & armed_q & ~line_s;
  assign clr_evt = stat_wr & ~stat_wdata & rd_seen_q;

  always_comb begin
    armed_d   = line_s ? 1'b0 : (armed_q | (ch_vld & ch_ferr));
    active_d  = line_s ? 1'b0 : (active_q | set_evt);
    rd_seen_d = stat_wr ? 1'b0 : (rd_seen_q | (stat_rd & flag_q));
    if (set_evt)      flag_d = 1'b1;
    else if (clr_evt) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      active_q  <= 1'b0;
      rd_seen_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      active_q  <= active_d;
      rd_seen_q <= rd_seen_d;
      flag_q    <= flag_d;
    end
  end

  assign in_brk   = active_q | set_evt;
  assign brk_flag = flag_q;
endmodule

// File: rtl/uart_rx_brk_tracker.sv
module uart_rx_brk_tracker
  import uart_brk_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_vld,
  input  logic [CHAR_W-1:0] ch_data,
  input  logic              ch_ferr,
  input  logic              rxd,
  input  logic              pop,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic              stat_wdata,
  output logic [CHAR_W-1:0] head_data,
  output logic              head_ferr,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              brk_flag
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             line_s;
  logic             in_brk;
  logic             store_en;
  rx_entry_t        wr_entry;
  rx_entry_t        head_entry;
  logic [CNT_W-1:0] fifo_cnt;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_async (rxd),
    .line_sync  (line_s)
  );

  brk_ctrl u_brk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_vld     (ch_vld),
    .ch_ferr    (ch_ferr),
    .line_s     (line_s),
    .stat_rd    (stat_rd),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .in_brk     (in_brk),
    .brk_flag   (brk_flag)
  );

  // nulls during a break are the receiver echoing the held space
  assign store_en      = ch_vld & ~(in_brk & (ch_data == '0));
  assign wr_entry.ferr = ch_ferr;
  assign wr_entry.data = ch_data;

  rx_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (store_en),
    .push_entry (wr_entry),
    .pop        (pop),
    .head       (head_entry),
    .empty      (fifo_empty),
    .full       (fifo_full),
    .count      (fifo_cnt)
  );

  assign head_data = head_entry.data;
  assign head_ferr = head_entry.ferr & ~fifo_empty;
endmodule

// File: rtl/uart_rx_brk_tracker_chk.sv
module uart_rx_brk_tracker_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ch_vld,
  input logic [7:0]       ch_data,
  input logic             pop,
  input logic             stat_wr,
  input logic             stat_wdata,
  input logic             head_ferr,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic             brk_flag,
  input logic             in_brk,
  input logic [CNT_W-1:0] fifo_cnt
);
  p_ferr_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !head_ferr);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !pop) |=> fifo_full);

  p_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !ch_vld) |=> fifo_empty);

  p_brk_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(ch_vld));

  p_zero_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_brk && ch_vld && ch_data == 8'h00 && !pop) |=> fifo_cnt == $past(fifo_cnt));

  p_brk_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !stat_wr) |=> brk_flag);

  p_wr_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && stat_wr && stat_wdata) |=> brk_flag);
endmodule

bind uart_rx_brk_tracker uart_rx_brk_tracker_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_vld     (ch_vld),
  .ch_data    (ch_data),
  .pop        (pop),
  .stat_wr    (stat_wr),
  .stat_wdata (stat_wdata),
  .head_ferr  (head_ferr),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .brk_flag   (brk_flag),
  .in_brk     (in_brk),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/uart_rx_brk_tracker_tb_top.sv
module uart_rx_brk_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int WDOG_LIMIT = 20000;

  logic       clk, rst_n;
  logic       ch_vld, ch_ferr, rxd, pop, stat_rd, stat_wr, stat_wdata;
  logic [7:0] ch_data, head_data;
  logic       head_ferr, fifo_empty, fifo_full, brk_flag;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;
  bit in_break = 0;   // bench-side model of the break state
  logic [8:0] exp_q[$];

  uart_rx_brk_tracker #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_vld(ch_vld), .ch_data(ch_data),
    .ch_ferr(ch_ferr), .rxd(rxd), .pop(pop), .stat_rd(stat_rd),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .head_data(head_data),
    .head_ferr(head_ferr), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .brk_flag(brk_flag)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: offer one character and record what should be stored
  task automatic send(input logic [7:0] d, input logic fe);
    if (!(in_break && d == 8'h00) && exp_q.size() < DEPTH) exp_q.push_back({fe, d});
    ch_vld = 1; ch_data = d; ch_ferr = fe;
    @(negedge clk);
    ch_vld = 0; ch_data = '0; ch_ferr = 0;
  endtask

  // monitor: compare the head with the scoreboard front, then pop it
  task automatic pop_cmp(input string req);
    logic [8:0] e;
    e = exp_q.pop_front();
    check(req, {head_ferr, head_data}, e);
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) pop_cmp(req);
    check({req, " empty"}, fifo_empty, 1);
    check("R1 ferr when empty", head_ferr, 0);
  endtask

  task automatic set_line(input logic v);
    rxd = v;
    repeat (3) @(negedge clk);
    if (v) in_break = 0;
  endtask

  task automatic strobe_rd();
    stat_rd = 1; @(negedge clk); stat_rd = 0;
  endtask

  task automatic strobe_wr(input logic v);
    stat_wr = 1; stat_wdata = v; @(negedge clk); stat_wr = 0; stat_wdata = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG_LIMIT && !done) begin
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; ch_vld = 0; ch_data = 0; ch_ferr = 0; rxd = 1;
    pop = 0; stat_rd = 0; stat_wr = 0; stat_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    check("R11 empty", fifo_empty, 1);
    check("R11 brk", brk_flag, 0);
    check("R11 ferr", head_ferr, 0);

    // R1 mixed tags, ordering
    send(8'hA5, 0); send(8'h3C, 1); send(8'h00, 0);
    drain("R1 order/tag");

    // R3 pop on empty ignored
    pop = 1; @(negedge clk); pop = 0;
    check("R3 still empty", fifo_empty, 1);
    send(8'h77, 1);
    drain("R3 head after empty pop");

    // R2 overflow drop
    for (int i = 0; i < DEPTH + 2; i++) send(8'(i + 1), i[0]);
    check("R2 full", fifo_full, 1);
    drain("R2 contents");

    // R8 disarm on mark, and R4 sync path
    set_line(0);
    send(8'h81, 1);
    set_line(1);
    set_line(0);
    send(8'h00, 0);
    check("R8 no break", brk_flag, 0);
    drain("R8 stored");
    set_line(1);

    // R5 break detect, R6 null suppression
    set_line(0);
    send(8'h55, 1);
    check("R5 not yet", brk_flag, 0);
    in_break = 1;
    send(8'h00, 1);
    check("R5 break set", brk_flag, 1);
    send(8'h00, 1);
    send(8'h12, 0);
    check("R6 only nonzero stored", exp_q.size(), 2);
    // R7 resume on mark (R4: three edges after rxd rises)
    set_line(1);
    send(8'h00, 0);
    drain("R6/R7 stored");

    // R9 clear protocol
    strobe_wr(0);
    check("R9 write0 no read", brk_flag, 1);
    strobe_rd(); strobe_wr(1);
    check("R9 write1", brk_flag, 1);
    strobe_wr(0);
    check("R9 read consumed", brk_flag, 1);
    strobe_rd(); strobe_wr(0);
    check("R9 cleared", brk_flag, 0);

    // R10 set wins over clear
    set_line(0);
    send(8'h66, 1);
    in_break = 1;
    send(8'h00, 1);
    check("R10 break set", brk_flag, 1);
    strobe_rd();
    ch_vld = 1; ch_data = 8'h00; ch_ferr = 1; stat_wr = 1; stat_wdata = 0;
    @(negedge clk);
    ch_vld = 0; ch_ferr = 0; stat_wr = 0;
    check("R10 set wins", brk_flag, 1);
    strobe_rd(); strobe_wr(0);
    check("R10 later clear", brk_flag, 0);
    set_line(1);
    drain("R10 stored");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule